// File: doc/BRIEF.md
# Batched Parallel Memory Loader

This block fills an on-chip programmable memory from a byte source outside the chip. It puts a 14-bit address on its source port and reads back one 8-bit byte for each address. Addresses go upward through a parameterised map of up to four address windows, and any address that falls between windows is never fetched. Bytes are collected into an eight-lane buffer. A full buffer, or the last byte of a window, causes one program pulse of fixed length. That pulse writes every valid lane at the same time.

Each byte crosses a request/acknowledge pair. The loader raises request with a steady address, takes the byte on the rising edge of acknowledge, and then waits for acknowledge to fall before it presents the next address. If acknowledge is wired straight back to request, each byte takes two cycles and the source is never waited on. The time-select input, sampled at start, chooses the short or long pulse length.

After the last pulse the loader walks the same addresses a second time and compares each source byte with the memory read port. The outcome is shown on two indicators. Green blinks while loading and stays steadily on after a clean compare. Red lights if any byte differs.

Top module: `par_mem_loader`

## Requirements
- R1: While reset is held and in the first idle cycle after it, src_req, prog_strobe, busy, done, led_green and led_red are all 0.
- R2: Within one pass, each new request carries a strictly higher address than the previous one. Every address requested lies inside a window. With the default windows 0x010–0x01C and 0x040–0x047, one pass makes exactly 21 requests.
- R3: A byte is taken only on a rising edge of src_ack. src_req is low while a pulse is active. A new request is raised only once src_ack is low.
- R4: With src_ack tied to src_req, loading and verifying run to done with no wait states.
- R5: A pulse fed by a full buffer has prog_lane_en = 8'hFF. Lane i programs address prog_addr+i, and its byte sits in prog_data bits [8i+7:8i].
- R6: A window end that leaves fewer than eight bytes produces a pulse whose enable bits are set only for the valid lanes, counted from lane 0. For the window 0x010–0x01C that pulse has prog_addr 0x018 and prog_lane_en 8'h1F.
- R7: prog_strobe stays high for exactly PULSE_SHORT cycles when long_pulse was 0 at start, and exactly PULSE_LONG cycles when it was 1. Address, enables and data do not change during the pulse.
- R8: During loading, led_green changes state for the first time BLINK_HALF cycles after busy rises, and again every BLINK_HALF cycles after that.
- R9: The second pass starts only after the last pulse and re-requests every mapped address. If every byte matches, the block ends with done=1, led_green=1 and led_red=0.
- R10: If any compared byte differs, the block ends with done=1, led_red=1 and led_green=0.
- R11: busy is 1 from the cycle after start is taken until done rises, and busy and done are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; accepted when idle or done |
| long_pulse | input | 1 | Time select, sampled at start: 0 short pulse, 1 long pulse |
| src_addr | output | 14 | Address to the source and to the memory read port |
| src_req | output | 1 | Request to the source |
| src_ack | input | 1 | Acknowledge from the source |
| src_data | input | 8 | Byte from the source |
| mem_rdata | input | 8 | Memory byte at src_addr, read combinationally |
| prog_strobe | output | 1 | Program pulse |
| prog_addr | output | 14 | Address of lane 0 of the batch |
| prog_lane_en | output | 8 | Per-lane write enable |
| prog_data | output | 64 | Eight bytes, lane i in bits [8i+7:8i] |
| busy | output | 1 | Load or verify in progress |
| done | output | 1 | Finished |
| mismatch | output | 1 | Verify found a difference (valid with done) |
| led_green | output | 1 | Blinks while loading; steady on after a clean verify |
| led_red | output | 1 | On after a failed verify |

## Verification
A byte is taken on the same clock edge where acknowledge is first seen high. The pulse for a batch starts one edge after the gap state sees acknowledge low. busy is visible one edge after start, and the done flags together with the indicators appear one edge after the final gap of the verify pass. The bench drives inputs 5 ns after a rising edge and samples every output on the falling edge. Each check is therefore taken in the half-cycle after the edge where its value was registered. Pulse widths, blink intervals and request orderings are measured by counting falling-edge samples, and the expected batches come from a queue that the driver fills before each run.

// File: rtl/plm_pkg.sv
package plm_pkg;

    localparam int ADDR_W = 14;
    localparam int BYTE_W = 8;
    localparam int LANES  = 8;
    localparam int MAX_SEG = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LREQ,
        ST_LGAP,
        ST_PROG,
        ST_VREQ,
        ST_VGAP,
        ST_DONE
    } plm_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]       base;
        logic [LANES-1:0]        lanes;
        logic [LANES*BYTE_W-1:0] data;
    } plm_batch_t;

    // enables must be a run of ones starting at lane 0
    function automatic logic lanes_from_zero(logic [LANES-1:0] l);
        return (l & (l + LANES'(1))) == '0;
    endfunction

endpackage

// File: rtl/plm_addr_seq.sv
module plm_addr_seq
    import plm_pkg::*;
#(
    parameter int NUM_SEG = 2,
    parameter logic [MAX_SEG-1:0][ADDR_W-1:0] SEG_LO = {14'h0, 14'h0, 14'h040, 14'h010},
    parameter logic [MAX_SEG-1:0][ADDR_W-1:0] SEG_HI = {14'h0, 14'h0, 14'h047, 14'h01C}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              seg_last,
    output logic              all_last
);
    localparam int SW = $clog2(MAX_SEG);

    logic [SW-1:0] seg;

    assign seg_last = (addr == SEG_HI[seg]);
    assign all_last = seg_last && (seg == SW'(NUM_SEG - 1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            seg  <= '0;
            addr <= SEG_LO[0];
        end else if (advance) begin
            if (seg_last) begin
                seg  <= seg + SW'(1);
                addr <= SEG_LO[seg + SW'(1)];
            end else begin
                addr <= addr + ADDR_W'(1);
            end
        end
    end

    p_addr_ascend_r2: assert property (@(posedge clk) disable iff (rst)
        advance && !restart && !all_last |=> addr > $past(addr));

endmodule

// File: rtl/plm_batch_buf.sv
module plm_batch_buf
    import plm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ADDR_W-1:0] addr_in,
    output plm_batch_t        batch,
    output logic              full
);
    localparam int CW = $clog2(LANES + 1);
    localparam int LW = $clog2(LANES);

    logic [CW-1:0] cnt;

    assign full = (cnt == CW'(LANES));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            batch <= '0;
        end else if (clear) begin
            cnt         <= '0;
            batch.lanes <= '0;
        end else if (wr) begin
            if (cnt == '0) batch.base <= addr_in;
            batch.data[cnt[LW-1:0]*BYTE_W +: BYTE_W] <= byte_in;
            batch.lanes[cnt[LW-1:0]] <= 1'b1;
            cnt <= cnt + CW'(1);
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        wr |-> !full);

endmodule

// File: rtl/plm_blink.sv
module plm_blink #(
    parameter int HALF = 8333333
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic out
);
    localparam int BW = $clog2(HALF + 1);

    logic [BW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            out <= 1'b0;
        end else if (cnt == BW'(HALF - 1)) begin
            cnt <= '0;
            out <= ~out;
        end else begin
            cnt <= cnt + BW'(1);
        end
    end

    p_blink_hold_r8: assert property (@(posedge clk) disable iff (rst)
        en && $past(en) && (cnt != '0) |-> $stable(out));

endmodule

// File: rtl/par_mem_loader.sv
module par_mem_loader
    import plm_pkg::*;
#(
    parameter int PULSE_SHORT = 250000,
    parameter int PULSE_LONG  = 500000,
    parameter int BLINK_HALF  = 8333333,
    parameter int NUM_SEG     = 2,
    parameter logic [MAX_SEG-1:0][ADDR_W-1:0] SEG_LO = {14'h0, 14'h0, 14'h040, 14'h010},
    parameter logic [MAX_SEG-1:0][ADDR_W-1:0] SEG_HI = {14'h0, 14'h0, 14'h047, 14'h01C}
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    long_pulse,
    output logic [ADDR_W-1:0]       src_addr,
    output logic                    src_req,
    input  logic                    src_ack,
    input  logic [BYTE_W-1:0]       src_data,
    input  logic [BYTE_W-1:0]       mem_rdata,
    output logic                    prog_strobe,
    output logic [ADDR_W-1:0]       prog_addr,
    output logic [LANES-1:0]        prog_lane_en,
    output logic [LANES*BYTE_W-1:0] prog_data,
    output logic                    busy,
    output logic                    done,
    output logic                    mismatch,
    output logic                    led_green,
    output logic                    led_red
);
    localparam int PMAX = (PULSE_LONG > PULSE_SHORT) ? PULSE_LONG : PULSE_SHORT;
    localparam int PW   = $clog2(PMAX + 1);

    plm_state_e state, nxt;
    logic          ack_q, ack_rise;
    logic [PW-1:0] pcnt, plen;
    logic          pulse_end;
    logic          seq_adv, seq_rst, buf_wr, buf_clr, vfail;
    logic          seg_last, all_last, buf_full;
    logic          loading, blink;
    plm_batch_t    batch;

    plm_addr_seq #(.NUM_SEG(NUM_SEG), .SEG_LO(SEG_LO), .SEG_HI(SEG_HI)) u_seq (
        .clk(clk), .rst(rst), .restart(seq_rst), .advance(seq_adv),
        .addr(src_addr), .seg_last(seg_last), .all_last(all_last));

    plm_batch_buf u_buf (
        .clk(clk), .rst(rst), .clear(buf_clr), .wr(buf_wr),
        .byte_in(src_data), .addr_in(src_addr), .batch(batch), .full(buf_full));

    plm_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst(rst), .en(loading), .out(blink));

    assign ack_rise  = src_ack && !ack_q;
    assign pulse_end = (pcnt == plen - PW'(1));

    always_comb begin
        nxt     = state;
        seq_adv = 1'b0;
        seq_rst = 1'b0;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        vfail   = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: if (start) begin
                nxt = ST_LREQ; seq_rst = 1'b1; buf_clr = 1'b1;
            end
            ST_LREQ: if (ack_rise) begin
                buf_wr = 1'b1; nxt = ST_LGAP;
            end
            ST_LGAP: if (!src_ack) begin
                if (buf_full || seg_last) nxt = ST_PROG;
                else begin seq_adv = 1'b1; nxt = ST_LREQ; end
            end
            ST_PROG: if (pulse_end) begin
                buf_clr = 1'b1;
                if (all_last) begin seq_rst = 1'b1; nxt = ST_VREQ; end
                else begin seq_adv = 1'b1; nxt = ST_LREQ; end
            end
            ST_VREQ: if (ack_rise) begin
                vfail = (src_data != mem_rdata); nxt = ST_VGAP;
            end
            ST_VGAP: if (!src_ack) begin
                if (all_last) nxt = ST_DONE;
                else begin seq_adv = 1'b1; nxt = ST_VREQ; end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ack_q    <= 1'b0;
            pcnt     <= '0;
            plen     <= PW'(PULSE_SHORT);
            mismatch <= 1'b0;
        end else begin
            state <= nxt;
            ack_q <= src_ack;
            pcnt  <= (state == ST_PROG && !pulse_end) ? pcnt + PW'(1) : '0;
            if ((state == ST_IDLE || state == ST_DONE) && start) begin
                mismatch <= 1'b0;
                plen     <= long_pulse ? PW'(PULSE_LONG) : PW'(PULSE_SHORT);
            end else if (vfail) begin
                mismatch <= 1'b1;
            end
        end
    end

    assign loading      = (state == ST_LREQ) || (state == ST_LGAP) || (state == ST_PROG);
    assign src_req      = (state == ST_LREQ) || (state == ST_VREQ);
    assign prog_strobe  = (state == ST_PROG);
    assign prog_addr    = batch.base;
    assign prog_lane_en = batch.lanes;
    assign prog_data    = batch.data;
    assign busy         = (state != ST_IDLE) && (state != ST_DONE);
    assign done         = (state == ST_DONE);
    assign led_green    = loading ? blink : (done && !mismatch);
    assign led_red      = done && mismatch;

    p_no_req_in_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        prog_strobe |-> !src_req);
    p_lanes_from_zero_r6: assert property (@(posedge clk) disable iff (rst)
        prog_strobe |-> (prog_lane_en != '0) && lanes_from_zero(prog_lane_en));
    p_pulse_hold_r7: assert property (@(posedge clk) disable iff (rst)
        prog_strobe && $past(prog_strobe) |->
            $stable(prog_addr) && $stable(prog_lane_en) && $stable(prog_data));
    p_done_excl_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !src_req && !prog_strobe);
    p_led_excl_r10: assert property (@(posedge clk) disable iff (rst)
        led_red |-> !led_green && !busy);

endmodule

// File: tb/par_mem_loader_test.sv
module par_mem_loader_test;
    localparam int PS = 12;
    localparam int PL = 30;
    localparam int BL = 5;

    typedef struct {
        int          base;
        int          lanes;
        logic [63:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        long_pulse = 1'b0;
    logic [13:0] src_addr;
    logic        src_req, src_ack;
    logic [7:0]  src_data, mem_rdata;
    logic        prog_strobe;
    logic [13:0] prog_addr;
    logic [7:0]  prog_lane_en;
    logic [63:0] prog_data;
    logic        busy, done, mismatch, led_green, led_red;

    logic        loop_mode = 1'b1;
    logic        ack_drv = 1'b0;
    logic        clear_mem = 1'b0;
    int          bad_addr = -1;
    logic [7:0]  memarr [0:127];

    exp_t q[$];
    int   errors = 0, checks = 0, cyc = 0;
    int   exp_w = PS;
    int   nreq, prev_addr, passes, batches, wcnt;
    int   busy_t, g1_t, g2_t, gchg;
    logic p_strobe, p_req, p_green, p_busy;

    always #10 clk = ~clk;

    function automatic logic [7:0] srcb(int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    function automatic logic in_seg(int a);
        return (a >= 'h10 && a <= 'h1C) || (a >= 'h40 && a <= 'h47);
    endfunction

    assign src_ack   = loop_mode ? src_req : ack_drv;
    assign src_data  = srcb(int'(src_addr));
    assign mem_rdata = (src_addr < 14'd128) ? memarr[src_addr[6:0]] : 8'hFF;

    par_mem_loader #(.PULSE_SHORT(PS), .PULSE_LONG(PL), .BLINK_HALF(BL)) uut (
        .clk(clk), .rst(rst), .start(start), .long_pulse(long_pulse),
        .src_addr(src_addr), .src_req(src_req), .src_ack(src_ack),
        .src_data(src_data), .mem_rdata(mem_rdata),
        .prog_strobe(prog_strobe), .prog_addr(prog_addr),
        .prog_lane_en(prog_lane_en), .prog_data(prog_data),
        .busy(busy), .done(done), .mismatch(mismatch),
        .led_green(led_green), .led_red(led_red));

    task automatic chk(input logic ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // source that answers after a delay when not looped back
    always @(posedge clk) begin
        #5;
        if (!loop_mode) begin
            if (!src_req) ack_drv = 1'b0;
            else if (!ack_drv) begin
                repeat (2) @(posedge clk);
                #5 ack_drv = 1'b1;
            end
        end
    end

    // monitor: memory model, scoreboard, request and indicator checks
    always @(negedge clk) begin
        if (clear_mem) begin
            for (int i = 0; i < 128; i++) memarr[i] = 8'hFF;
        end
        if (prog_strobe && !p_strobe) begin
            int bad = 0;
            exp_t e;
            for (int i = 0; i < 8; i++)
                if (prog_lane_en[i] && (int'(prog_addr) + i) != bad_addr)
                    memarr[7'(int'(prog_addr) + i)] = prog_data[8*i +: 8];
            batches++;
            wcnt = 1;
            if (q.size() == 0) chk(1'b0, "R5 unexpected pulse", prog_addr, 0);
            else begin
                e = q.pop_front();
                chk(int'(prog_addr) == e.base, "R5 batch address", prog_addr, e.base);
                chk(int'(prog_lane_en) == e.lanes, "R6 lane enables", prog_lane_en, e.lanes);
                for (int i = 0; i < 8; i++)
                    if (e.lanes[i] && prog_data[8*i +: 8] != e.data[8*i +: 8]) bad++;
                chk(bad == 0, "R5 lane data", prog_data, e.data);
            end
        end else if (prog_strobe) wcnt++;
        else if (p_strobe) chk(wcnt == exp_w, "R7 pulse width", wcnt, exp_w);

        if (src_req && !p_req) begin
            nreq++;
            if (!loop_mode) chk(!src_ack, "R3 ack low at new request", src_ack, 0);
            chk(in_seg(int'(src_addr)), "R2 address inside window", src_addr, 0);
            if (int'(src_addr) <= prev_addr) begin
                passes++;
                chk(batches == 3, "R9 verify after last pulse", batches, 3);
            end
            prev_addr = int'(src_addr);
        end

        if (busy && !p_busy) busy_t = cyc;
        if (busy && !prog_strobe && led_green != p_green && src_req == p_req) begin
            gchg++;
            if (gchg == 1) g1_t = cyc;
            if (gchg == 2) g2_t = cyc;
        end else if (busy && led_green != p_green) begin
            gchg++;
            if (gchg == 1) g1_t = cyc;
            if (gchg == 2) g2_t = cyc;
        end
        p_strobe = prog_strobe;
        p_req    = src_req;
        p_green  = led_green;
        p_busy   = busy;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            summary();
        end
    end

    task automatic push_seg(int lo, int hi);
        for (int a = lo; a <= hi; a += 8) begin
            exp_t e;
            e.base = a; e.lanes = 0; e.data = '0;
            for (int i = 0; i < 8; i++)
                if (a + i <= hi) begin
                    e.lanes |= (1 << i);
                    e.data[8*i +: 8] = srcb(a + i);
                end
            q.push_back(e);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic run(input logic lp, input logic sel, input int bad, input string tag);
        int t;
        loop_mode = lp; long_pulse = sel; bad_addr = bad;
        exp_w = sel ? PL : PS;
        q.delete();
        push_seg('h10, 'h1C);
        push_seg('h40, 'h47);
        nreq = 0; prev_addr = -1; passes = 1; batches = 0; gchg = 0;
        clear_mem = 1'b1;
        tick();
        clear_mem = 1'b0;
        start = 1'b1;
        tick();
        start = 1'b0;
        @(negedge clk);
        chk(busy && !done, {tag, " R11 busy after start"}, {busy, done}, 2'b10);
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            chk(!(busy && done), "R11 busy and done exclusive", {busy, done}, 2'b10);
            t++;
        end
        chk(done, {tag, " R4 reached done"}, done, 1);
        chk(q.size() == 0 && batches == 3, {tag, " R5 all batches pulsed"}, batches, 3);
        chk(nreq == 42, {tag, " R2 request count"}, nreq, 42);
        chk(passes == 2, {tag, " R9 two passes"}, passes, 2);
        if (bad < 0) begin
            chk(led_green && !led_red && !mismatch, {tag, " R9 clean verify"},
                {led_green, led_red}, 2'b10);
            repeat (4) @(negedge clk);
            chk(led_green, {tag, " R9 green steady"}, led_green, 1);
        end else begin
            chk(led_red && !led_green && mismatch, {tag, " R10 mismatch flagged"},
                {led_green, led_red}, 2'b01);
        end
    endtask

    initial begin
        p_strobe = 0; p_req = 0; p_green = 0; p_busy = 0;
        for (int i = 0; i < 128; i++) memarr[i] = 8'hFF;
        repeat (3) tick();
        @(negedge clk);
        chk(!src_req && !prog_strobe && !busy && !done && !led_green && !led_red,
            "R1 outputs during reset", {src_req, prog_strobe, busy, done, led_green, led_red}, 0);
        tick();
        rst = 1'b0;
        @(negedge clk);
        chk(!src_req && !prog_strobe && !busy && !done && !led_green && !led_red,
            "R1 outputs idle after reset", {src_req, prog_strobe, busy, done, led_green, led_red}, 0);

        run(1'b1, 1'b0, -1, "loopback short");
        chk(g1_t - busy_t == BL, "R8 first blink edge", g1_t - busy_t, BL);
        chk(g2_t - g1_t == BL, "R8 blink interval", g2_t - g1_t, BL);

        run(1'b0, 1'b1, -1, "handshake long");
        run(1'b1, 1'b0, 'h1A, "bad cell");
        summary();
    end

endmodule